// File: doc/BRIEF.md
# Prioritised Interrupt Recognition Unit

This block decides when a small CPU core leaves its instruction stream for a service routine and which vector address the core fetches next. Its requests come from several sources. A bank of level-sensitive device lines and a shared active-low external line can be masked. A non-maskable pin is gated only by its own mask bit. A software-interrupt request and an illegal-opcode trap are always honoured. A request waits for the core's end-of-instruction strobe. On that cycle the highest-ranked eligible source wins, and every other active request stays pending at its input.

The unit holds the core's two mask bits. The maskable-interrupt bit (I) is set by reset and by every accepted interrupt, and the core can overwrite it when it executes its enable, disable and return instructions. The non-maskable mask bit (X) is set only by reset. Software can clear it, and nothing sets it again until the next reset. After reset is released, the unit issues one take pulse carrying the reset vector so that the core starts up through the same fetch path it uses for any other vector. Saving the core's registers and fetching the vector are left to the core.

Top module: `intr_recog_unit`

## Requirements
- R1: While reset is held, take_o is 0, i_bit_o is 1 and x_bit_o is 1. On the first clock edge after reset is released, take_o pulses for one cycle with vec_o = 0xFFFE, the reset vector.
- R2: Apart from the reset pulse, take_o rises only in the cycle after a clock edge at which insn_done_i was 1. A request held while insn_done_i is 0 produces no take.
- R3: Eligible sources are ranked in this order, highest first: trap, software interrupt, non-maskable pin, external line, then device line 0 up to line NUM_DEV-1. The vector for source rank r is 0xFFFE − 2·r, with reset at rank 0 and device line k at rank 5+k. This gives trap 0xFFFC, software 0xFFFA, non-maskable 0xFFF8, external 0xFFF6 and device k 0xFFF4 − 2k.
- R4: Every accepted interrupt sets i_bit_o to 1 at the same edge that raises take_o, so a maskable source that is still held is not taken again at the next boundary.
- R5: While i_bit_o is 1, device lines and the external line are never taken.
- R6: Trap and software requests are taken at a boundary whatever the value of i_bit_o.
- R7: The non-maskable pin is ignored while x_bit_o is 1. A one-cycle pulse on x_clr_i clears x_bit_o, and no input other than reset sets it back to 1.
- R8: The external line is active low: ext_req_ni = 0 requests and ext_req_ni = 1 does not.
- R9: Requests are levels. A lower-ranked source that loses, or is masked, stays pending and is taken at the first boundary after the winner is withdrawn and the mask allows it.
- R10: i_wr_i = 1 loads i_wdata_i into i_bit_o at the next edge. When an interrupt is accepted at that same edge, i_bit_o becomes 1 regardless of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_done_i | input | 1 | Strobe high in the last cycle of each instruction |
| dev_req_i | input | NUM_DEV | Level-sensitive device requests, bit 0 ranked highest |
| ext_req_ni | input | 1 | Shared external request line, active low |
| nmi_req_i | input | 1 | Non-maskable pin request |
| swi_req_i | input | 1 | Software-interrupt request from the current instruction |
| trap_req_i | input | 1 | Illegal-opcode trap from the current instruction |
| i_wr_i | input | 1 | Write strobe for the I mask bit |
| i_wdata_i | input | 1 | New value for the I mask bit |
| x_clr_i | input | 1 | Clear request for the X mask bit |
| i_bit_o | output | 1 | Current I mask bit |
| x_bit_o | output | 1 | Current X mask bit |
| take_o | output | 1 | One-cycle pulse: interrupt accepted |
| vec_o | output | VEC_W | Vector address of the accepted source, valid with take_o |

## Verification
Two events can land on the same clock edge: an interrupt accepted at an instruction boundary, and a software write that clears the I bit. The bench provokes this by holding a device line and, in the same cycle, raising insn_done_i together with i_wr_i and i_wdata_i = 0. It judges the result by checking that take_o carries the device vector and that i_bit_o reads 1 afterwards. A second collision drives several sources in the same boundary cycle and checks the winner's vector. It then checks that each lower-ranked source is taken at a later boundary once the winner has been withdrawn.

// File: rtl/intr_pkg.sv
package intr_pkg;
   // fixed rank of each non-device source; device k sits at DEV_BASE + k
   localparam int unsigned RANK_RST  = 0;
   localparam int unsigned RANK_TRAP = 1;
   localparam int unsigned RANK_SWI  = 2;
   localparam int unsigned RANK_NMI  = 3;
   localparam int unsigned RANK_EXT  = 4;
   localparam int unsigned DEV_BASE  = 5;

   function automatic int unsigned src_count(input int unsigned n_dev);
      return DEV_BASE + n_dev;
   endfunction
endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
   parameter int unsigned N     = 13,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   if (N < 2) begin : g_bad_n
      $error("intr_prio_pick: N must be at least 2");
   end

   // lowest index wins: scan from the top so the last hit is the smallest
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
      any_o = |req_i;
   end
endmodule

// File: rtl/intr_vec_map.sv
module intr_vec_map #(
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned VEC_W    = 16,
   parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE,
   parameter int unsigned VEC_STEP = 2
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [VEC_W-1:0] vec_o
);
   localparam logic [VEC_W-1:0] STEP_V = VEC_W'(VEC_STEP);

   if (VEC_STEP == 0) begin : g_bad_step
      $error("intr_vec_map: VEC_STEP must be non-zero");
   end

   always_comb begin
      vec_o = VEC_TOP - (VEC_W'(idx_i) * STEP_V);
   end
endmodule

// File: rtl/intr_mask_regs.sv
module intr_mask_regs (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic take_i,
   input  logic i_wr_i,
   input  logic i_wdata_i,
   input  logic x_clr_i,
   output logic i_bit_o,
   output logic x_bit_o
);
   // I: set by reset and by every accepted interrupt; software write otherwise
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     i_bit_o <= 1'b1;
      else if (take_i) i_bit_o <= 1'b1;
      else if (i_wr_i) i_bit_o <= i_wdata_i;
   end

   // X: set only by reset, clear-only afterwards
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      x_bit_o <= 1'b1;
      else if (x_clr_i) x_bit_o <= 1'b0;
   end

   assert_x_stays_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !x_bit_o |=> !x_bit_o);

   assert_take_sets_i_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> i_bit_o);

   assert_write_loads_i_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (i_wr_i && !take_i) |=> (i_bit_o == $past(i_wdata_i)));
endmodule

// File: rtl/intr_recog_unit.sv
module intr_recog_unit #(
   parameter int unsigned NUM_DEV  = 8,
   parameter int unsigned VEC_W    = 16,
   parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE,
   parameter int unsigned VEC_STEP = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               insn_done_i,
   input  logic [NUM_DEV-1:0] dev_req_i,
   input  logic               ext_req_ni,
   input  logic               nmi_req_i,
   input  logic               swi_req_i,
   input  logic               trap_req_i,
   input  logic               i_wr_i,
   input  logic               i_wdata_i,
   input  logic               x_clr_i,
   output logic               i_bit_o,
   output logic               x_bit_o,
   output logic               take_o,
   output logic [VEC_W-1:0]   vec_o
);
   import intr_pkg::*;

   localparam int unsigned NSRC  = src_count(NUM_DEV);
   localparam int unsigned IDX_W = $clog2(NSRC);
   localparam logic [VEC_W-1:0] RST_VEC = VEC_TOP;
   localparam logic [VEC_W-1:0] NMI_VEC = VEC_TOP - VEC_W'(RANK_NMI * VEC_STEP);

   if (NUM_DEV < 1 || NUM_DEV > 64) begin : g_bad_dev
      $error("intr_recog_unit: NUM_DEV out of range 1..64");
   end
   if ((NSRC - 1) * VEC_STEP > VEC_TOP) begin : g_bad_vec
      $error("intr_recog_unit: vector table runs below zero");
   end

   logic             rst_pend_q;
   logic [NSRC-1:0]  src_req;
   logic             any_req;
   logic [IDX_W-1:0] win_idx;
   logic [VEC_W-1:0] win_vec;

   // eligibility of each source, index = rank
   always_comb begin
      src_req            = '0;
      src_req[RANK_RST]  = rst_pend_q;
      src_req[RANK_TRAP] = insn_done_i & trap_req_i;
      src_req[RANK_SWI]  = insn_done_i & swi_req_i;
      src_req[RANK_NMI]  = insn_done_i & nmi_req_i & ~x_bit_o;
      src_req[RANK_EXT]  = insn_done_i & ~ext_req_ni & ~i_bit_o;
   end

   for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
      logic dev_ok;
      assign dev_ok = insn_done_i & dev_req_i[k] & ~i_bit_o;
      always_comb begin
         src_pick_slot[k] = dev_ok;
      end
   end

   logic [NUM_DEV-1:0] src_pick_slot;
   logic [NSRC-1:0]    src_all;
   assign src_all = src_req | (NSRC'(src_pick_slot) << DEV_BASE);

   intr_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
      .req_i (src_all),
      .any_o (any_req),
      .idx_o (win_idx)
   );

   intr_vec_map #(.IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP),
                  .VEC_STEP(VEC_STEP)) u_vmap (
      .idx_i (win_idx),
      .vec_o (win_vec)
   );

   intr_mask_regs u_mask (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_i    (any_req),
      .i_wr_i    (i_wr_i),
      .i_wdata_i (i_wdata_i),
      .x_clr_i   (x_clr_i),
      .i_bit_o   (i_bit_o),
      .x_bit_o   (x_bit_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rst_pend_q <= 1'b1;
         take_o     <= 1'b0;
         vec_o      <= '0;
      end else begin
         take_o <= any_req;
         if (any_req) begin
            vec_o      <= win_vec;
            rst_pend_q <= 1'b0;
         end
      end
   end

   assert_take_at_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && vec_o != RST_VEC) |-> $past(insn_done_i));

   assert_masked_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && $past(i_bit_o)) |-> (vec_o >= NMI_VEC));

   assert_nmi_gated_by_x_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && vec_o == NMI_VEC) |-> !$past(x_bit_o));

   assert_single_reset_take_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && vec_o == RST_VEC) |=> !(take_o && vec_o == RST_VEC));
endmodule

// File: tb/sim_intr_recog_unit.sv
module sim_intr_recog_unit;
   localparam int NDEV = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            insn_done = 1'b0;
   logic [NDEV-1:0] dev = '0;
   logic            ext_n = 1'b1;
   logic            nmi = 1'b0;
   logic            swi = 1'b0;
   logic            trap = 1'b0;
   logic            i_wr = 1'b0;
   logic            i_wd = 1'b0;
   logic            x_clr = 1'b0;
   logic            i_bit, x_bit, take;
   logic [15:0]     vec;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   intr_recog_unit u0 (
      .clk_i(clk), .rst_ni(rst_n), .insn_done_i(insn_done), .dev_req_i(dev),
      .ext_req_ni(ext_n), .nmi_req_i(nmi), .swi_req_i(swi), .trap_req_i(trap),
      .i_wr_i(i_wr), .i_wdata_i(i_wd), .x_clr_i(x_clr),
      .i_bit_o(i_bit), .x_bit_o(x_bit), .take_o(take), .vec_o(vec)
   );

   // fields: imask, dev[7:0], ext_n, nmi, swi, trap, exp_take, exp_vec[15:0]
   localparam int NV = 10;
   localparam logic [29:0] TBL [NV] = '{
      {1'b0, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFF4},  // R3 dev0
      {1'b0, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFE6},  // R3 dev7
      {1'b0, 8'h28, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFEE},  // R3 dev3 over dev5
      {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},  // R5 masked
      {1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFF6},  // R8 ext over devs
      {1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFA},  // R6 swi with I=1
      {1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFC},  // R6 trap over swi
      {1'b0, 8'h04, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFF0},  // R7 nmi with X=1
      {1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},  // R7 nmi masked
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFC}   // R3 trap over ext
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_i(input logic v);
      @(negedge clk); i_wr = 1'b1; i_wd = v;
      @(negedge clk); i_wr = 1'b0;
   endtask

   // one boundary strobe; returns sampled after the capturing edge
   task automatic boundary();
      @(negedge clk); insn_done = 1'b1;
      @(negedge clk); insn_done = 1'b0;
   endtask

   task automatic clear_reqs();
      dev = '0; ext_n = 1'b1; nmi = 1'b0; swi = 1'b0; trap = 1'b0;
   endtask

   initial begin
      #1_600_000;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(take, 0, "R1 take in reset");
      chk(i_bit, 1, "R1 I in reset");
      chk(x_bit, 1, "R1 X in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(take, 1, "R1 reset take");
      chk(vec, 32'hFFFE, "R1 reset vector");
      @(negedge clk);
      chk(take, 0, "R1 single pulse");

      // table walk
      for (int n = 0; n < NV; n++) begin
         write_i(TBL[n][29]);
         @(negedge clk);
         dev = TBL[n][28:21]; ext_n = TBL[n][20]; nmi = TBL[n][19];
         swi = TBL[n][18]; trap = TBL[n][17];
         boundary();
         chk(take, TBL[n][16], $sformatf("R3 table %0d take", n));
         if (TBL[n][16]) chk(vec, TBL[n][15:0], $sformatf("R3 table %0d vec", n));
         clear_reqs();
      end

      // R2: no boundary, no take
      write_i(1'b0);
      @(negedge clk); dev = 8'h01;
      repeat (3) begin
         @(negedge clk);
         chk(take, 0, "R2 no take without boundary");
      end
      boundary();
      chk(take, 1, "R2 take after boundary");
      chk(vec, 32'hFFF4, "R2 vector");
      // R4: I set, held device not retaken
      chk(i_bit, 1, "R4 I set by take");
      boundary();
      chk(take, 0, "R4 held device blocked");
      clear_reqs();

      // R9: swi wins, device remains pending then taken
      write_i(1'b0);
      @(negedge clk); swi = 1'b1; dev = 8'h02;
      boundary();
      chk(vec, 32'hFFFA, "R9 swi wins");
      @(negedge clk); swi = 1'b0;
      write_i(1'b0);
      boundary();
      chk(take, 1, "R9 pending device taken");
      chk(vec, 32'hFFF2, "R9 device1 vector");
      clear_reqs();

      // R10: plain write, then write colliding with a take
      write_i(1'b0);
      @(negedge clk);
      chk(i_bit, 0, "R10 write clears I");
      dev = 8'h01;
      @(negedge clk); insn_done = 1'b1; i_wr = 1'b1; i_wd = 1'b0;
      @(negedge clk); insn_done = 1'b0; i_wr = 1'b0;
      chk(take, 1, "R10 collision take");
      chk(vec, 32'hFFF4, "R10 collision vector");
      chk(i_bit, 1, "R10 take overrides write");
      clear_reqs();

      // R7: clear X, nmi now taken even with I=1
      @(negedge clk); x_clr = 1'b1;
      @(negedge clk); x_clr = 1'b0;
      chk(x_bit, 0, "R7 X cleared");
      nmi = 1'b1;
      boundary();
      chk(take, 1, "R7 nmi taken");
      chk(vec, 32'hFFF8, "R7 nmi vector");
      nmi = 1'b0;
      write_i(1'b1);
      write_i(1'b0);
      chk(x_bit, 0, "R7 X stays clear");
      // R3/R8: nmi beats ext line
      @(negedge clk); nmi = 1'b1; ext_n = 1'b0;
      boundary();
      chk(vec, 32'hFFF8, "R3 nmi over ext");
      @(negedge clk); nmi = 1'b0;
      write_i(1'b0);
      boundary();
      chk(vec, 32'hFFF6, "R8 ext pending taken");
      clear_reqs();
      @(negedge clk);
      chk(take, 0, "R2 idle no take");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule